// File: doc/BRIEF.md
# Hash Engine Block Sequencer

This block is the control front end placed before a multi-mode hash compression engine. It keeps the active algorithm code and counts the 32-bit message words written into the engine's block buffer. When a full block has arrived, it fires a single-cycle launch pulse. The first block of a message gets a "begin" pulse and every later block gets a "proceed" pulse. It then holds a busy status until the engine reports completion.

After the last block, an explicit copy step transfers the engine's result into a local digest store, one word per cycle. Software reads the digest from that store as 32-bit words and may stop early to take a truncated hash. The block also reports the digest size in bytes for the selected algorithm. Triggers that arrive while the block is busy are dropped and raise a sticky error flag.

The sequencer has three states, each named in the package:
- `ST_IDLE`: accepts words, mode writes, message restarts and copy requests.
- `ST_RUN`: the engine is compressing a block.
- `ST_LOAD`: the result is being copied.

It has four transitions:
- IDLE→RUN, on the last word of a block.
- RUN→IDLE, on `eng_done`.
- IDLE→LOAD, on `load_req`.
- LOAD→IDLE, after the final copy beat.

Top module: `hash_seq`

## Requirements
- R1: The algorithm codes are 0 SHA-1, 1 SHA-224, 2 SHA-256, 3 SHA-384, 4 SHA-512, 5 SHA-512/224 and 6 SHA-512/256. `dig_len` reports 20, 28, 32, 48, 64, 28 and 32 bytes respectively. After reset the code is 0.
- R2: A block is 16 words for codes 0 to 2 and 32 words for codes 3 to 6. The launch pulse appears in the cycle after the edge that accepts the last word of a block, and no pulse appears for earlier words.
- R3: The first block after reset or after an accepted `new_msg` raises `eng_start`, and every later block raises `eng_cont`. Each pulse lasts exactly one cycle, and the two are never high together.
- R4: `busy` is high from the cycle of a launch pulse until the edge after `eng_done` is sampled high, and then returns low.
- R5: A mode write with a code of 7 is rejected, and the previous code stays in force.
- R6: `load_req` in idle copies all 16 result words from `eng_result`, taking word i from bits [32*i+31:32*i]. `busy` stays high for exactly 16 cycles during the copy.
- R7: A word write, mode write, `new_msg` or `load_req` that arrives while `busy` is high has no effect, and it sets `err`. `err` stays set until a `new_msg` is accepted in idle.
- R8: `rd_data` returns digest word `rd_idx`. Indices at or beyond the digest word count of the current code (5, 7, 8, 12, 16, 7, 8) read as 0, and the store reads 0 after reset.
- R9: An accepted `new_msg` discards the words already counted toward a partially filled block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Algorithm code to write |
| new_msg | input | 1 | Begin a new message |
| word_wr | input | 1 | One message word written to the block buffer |
| load_req | input | 1 | Copy the engine result into the digest store |
| eng_done | input | 1 | Engine finished the current block |
| eng_result | input | 512 | Engine result words, word i at bits 32*i upward |
| rd_idx | input | 4 | Digest word index to read |
| eng_start | output | 1 | Launch pulse for the first block |
| eng_cont | output | 1 | Launch pulse for later blocks |
| eng_mode | output | 3 | Algorithm code in force |
| busy | output | 1 | Block is running or copying |
| err | output | 1 | Sticky flag for a trigger dropped while busy |
| dig_len | output | 7 | Digest size in bytes for the current code |
| rd_data | output | 32 | Digest word read out |

## Verification
The in-RTL assertions guard properties that must hold on every cycle:
- The two launch pulses are exclusive and each lasts one cycle.
- A launch always comes with busy.
- The copy ends on its final beat.
- The digest store changes only while copying.
- A rejected code leaves the mode unchanged.
- A trigger dropped while busy raises the error flag.

The directed scenarios cover what a single-cycle property cannot. They count the exact word at which each block boundary fires under both block sizes. They check the begin/proceed choice across message restarts and the discarding of a partial block. They measure the 16-cycle copy window and check the truncated readout after a mode change.

// File: rtl/hash_seq_pkg.sv
package hash_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int MODE_W    = 3;
    localparam int MODE_MAX  = 6;
    localparam int DIG_WORDS = 16;
    localparam int IDX_W     = $clog2(DIG_WORDS);
    localparam int CNT_W     = 5;
    localparam int LEN_W     = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hash_seq_mode_dec.sv
module hash_seq_mode_dec
    import hash_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  blk_last,
    output logic [CNT_W-1:0]  dig_words,
    output logic [LEN_W-1:0]  dig_bytes
);
    always_comb begin
        unique case (mode)
            3'd0: begin blk_last = 5'd15; dig_words = 5'd5;  end
            3'd1: begin blk_last = 5'd15; dig_words = 5'd7;  end
            3'd2: begin blk_last = 5'd15; dig_words = 5'd8;  end
            3'd3: begin blk_last = 5'd31; dig_words = 5'd12; end
            3'd4: begin blk_last = 5'd31; dig_words = 5'd16; end
            3'd5: begin blk_last = 5'd31; dig_words = 5'd7;  end
            3'd6: begin blk_last = 5'd31; dig_words = 5'd8;  end
            default: begin blk_last = 5'd15; dig_words = 5'd5; end
        endcase
        dig_bytes = {dig_words, 2'b00};
    end
endmodule

// File: rtl/hash_seq_fsm.sv
module hash_seq_fsm
    import hash_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_wr,
    input  logic             mode_wr,
    input  logic             new_msg,
    input  logic             load_req,
    input  logic             eng_done,
    input  logic [CNT_W-1:0] blk_last,
    output logic             eng_start,
    output logic             eng_cont,
    output logic             busy,
    output logic             err,
    output logic             cp_en,
    output logic [IDX_W-1:0] cp_idx,
    output logic             mode_ok
);
    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] lidx_q;
    logic             first_q;
    logic             blk_full;
    logic             any_trig;

    assign busy     = (state_q != ST_IDLE);
    assign blk_full = word_wr && !new_msg && !load_req && (cnt_q >= blk_last);
    assign any_trig = word_wr || mode_wr || new_msg || load_req;
    assign cp_en    = (state_q == ST_LOAD);
    assign cp_idx   = lidx_q;
    assign mode_ok  = (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (new_msg)       state_d = ST_IDLE;
                else if (load_req) state_d = ST_LOAD;
                else if (blk_full) state_d = ST_RUN;
            end
            ST_RUN:  if (eng_done) state_d = ST_IDLE;
            ST_LOAD: if (lidx_q == IDX_W'(DIG_WORDS - 1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_cont  <= 1'b0;
            err       <= 1'b0;
            cnt_q     <= '0;
            lidx_q    <= '0;
            first_q   <= 1'b1;
        end else begin
            eng_start <= 1'b0;
            eng_cont  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (new_msg) begin
                        first_q <= 1'b1;
                        cnt_q   <= '0;
                        err     <= 1'b0;
                    end else if (load_req) begin
                        lidx_q <= '0;
                    end else if (blk_full) begin
                        cnt_q     <= '0;
                        first_q   <= 1'b0;
                        eng_start <= first_q;
                        eng_cont  <= !first_q;
                    end else if (word_wr) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (any_trig) err <= 1'b1;
                end
                ST_LOAD: begin
                    lidx_q <= lidx_q + 1'b1;
                    if (any_trig) err <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_start && eng_cont));
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_cont_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cont |=> !eng_cont);
    assert_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start || eng_cont) |-> busy);
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && eng_done) |=> !busy);
    assert_load_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_en && lidx_q == IDX_W'(DIG_WORDS - 1)) |=> !busy);
    assert_busy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_wr) |=> err);
endmodule

// File: rtl/hash_seq_digest.sv
module hash_seq_digest
    import hash_seq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cp_en,
    input  logic [IDX_W-1:0]            cp_idx,
    input  logic [DIG_WORDS*WORD_W-1:0] src,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [CNT_W-1:0]            dig_words,
    output logic [WORD_W-1:0]           rd_data
);
    logic [DIG_WORDS-1:0][WORD_W-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else if (cp_en) store_q[cp_idx] <= src[cp_idx*WORD_W +: WORD_W];
    end

    always_comb begin
        if ({1'b0, rd_idx} < dig_words) rd_data = store_q[rd_idx];
        else                            rd_data = '0;
    end

    assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_en |=> $stable(store_q));
endmodule

// File: rtl/hash_seq.sv
module hash_seq
    import hash_seq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_wr,
    input  logic [MODE_W-1:0]           mode_in,
    input  logic                        new_msg,
    input  logic                        word_wr,
    input  logic                        load_req,
    input  logic                        eng_done,
    input  logic [DIG_WORDS*WORD_W-1:0] eng_result,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        eng_start,
    output logic                        eng_cont,
    output logic [MODE_W-1:0]           eng_mode,
    output logic                        busy,
    output logic                        err,
    output logic [LEN_W-1:0]            dig_len,
    output logic [WORD_W-1:0]           rd_data
);
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  blk_last;
    logic [CNT_W-1:0]  dig_words;
    logic              cp_en;
    logic [IDX_W-1:0]  cp_idx;
    logic              mode_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else if (mode_wr && mode_ok && (mode_in <= MODE_W'(MODE_MAX))) mode_q <= mode_in;
    end
    assign eng_mode = mode_q;

    hash_seq_mode_dec u_dec (
        .mode      (mode_q),
        .blk_last  (blk_last),
        .dig_words (dig_words),
        .dig_bytes (dig_len)
    );

    hash_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_wr   (word_wr),
        .mode_wr   (mode_wr),
        .new_msg   (new_msg),
        .load_req  (load_req),
        .eng_done  (eng_done),
        .blk_last  (blk_last),
        .eng_start (eng_start),
        .eng_cont  (eng_cont),
        .busy      (busy),
        .err       (err),
        .cp_en     (cp_en),
        .cp_idx    (cp_idx),
        .mode_ok   (mode_ok)
    );

    hash_seq_digest u_dig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp_en     (cp_en),
        .cp_idx    (cp_idx),
        .src       (eng_result),
        .rd_idx    (rd_idx),
        .dig_words (dig_words),
        .rd_data   (rd_data)
    );

    assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in > MODE_W'(MODE_MAX)) |=> $stable(eng_mode));
endmodule

// File: tb/sim_hash_seq.sv
module sim_hash_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_in = '0;
    logic         new_msg = 1'b0;
    logic         word_wr = 1'b0;
    logic         load_req = 1'b0;
    logic         eng_done = 1'b0;
    logic [511:0] eng_result = '0;
    logic [3:0]   rd_idx = '0;
    logic         eng_start, eng_cont, busy, err;
    logic [2:0]   eng_mode;
    logic [6:0]   dig_len;
    logic [31:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    hash_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .new_msg(new_msg), .word_wr(word_wr), .load_req(load_req),
        .eng_done(eng_done), .eng_result(eng_result), .rd_idx(rd_idx),
        .eng_start(eng_start), .eng_cont(eng_cont), .eng_mode(eng_mode),
        .busy(busy), .err(err), .dig_len(dig_len), .rd_data(rd_data)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_mode(input logic [2:0] m);
        @(negedge clk); mode_in = m; mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask
    task automatic pulse_word();
        @(negedge clk); word_wr = 1'b1;
        @(negedge clk); word_wr = 1'b0;
    endtask
    task automatic pulse_new();
        @(negedge clk); new_msg = 1'b1;
        @(negedge clk); new_msg = 1'b0;
    endtask
    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask
    task automatic pulse_load();
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0;
    endtask

    // writes n words, returns number of launch pulses seen before the last word
    task automatic feed(input int n, output int early);
        early = 0;
        for (int i = 0; i < n; i++) begin
            pulse_word();
            if (i < n - 1 && (eng_start || eng_cont)) early++;
        end
    endtask

    task automatic t_reset();
        check("R1 reset mode", eng_mode, 0);
        check("R1 reset len", dig_len, 20);
        check("R4 reset busy", busy, 0);
        check("R3 reset start", eng_start, 0);
        check("R7 reset err", err, 0);
        check("R8 reset read", rd_data, 0);
    endtask

    task automatic t_modes();
        int lens[7] = '{20, 28, 32, 48, 64, 28, 32};
        for (int m = 0; m < 7; m++) begin
            pulse_mode(3'(m));
            check("R1 digest length", dig_len, lens[m]);
        end
        pulse_mode(3'd2);
        pulse_mode(3'd7);
        check("R5 code 7 rejected", eng_mode, 2);
        check("R5 length kept", dig_len, 32);
    endtask

    task automatic t_first_and_next();
        int early;
        feed(16, early);
        check("R2 no early pulse 16w", early, 0);
        check("R3 first block start", eng_start, 1);
        check("R3 first block not cont", eng_cont, 0);
        check("R4 busy on launch", busy, 1);
        @(negedge clk);
        check("R3 start single cycle", eng_start, 0);
        repeat (3) @(negedge clk);
        check("R4 busy held", busy, 1);
        pulse_done();
        check("R4 idle after done", busy, 0);
        feed(16, early);
        check("R3 later block cont", eng_cont, 1);
        check("R3 later block not start", eng_start, 0);
        pulse_done();
    endtask

    task automatic t_reject();
        int early;
        feed(16, early);
        check("R4 busy for reject", busy, 1);
        pulse_word();
        pulse_word();
        pulse_load();
        check("R7 err set", err, 1);
        check("R7 load ignored", busy, 1);
        pulse_done();
        feed(16, early);
        check("R7 ignored words uncounted", early, 0);
        check("R7 pulse at 16th", eng_cont, 1);
        pulse_done();
        check("R7 err sticky", err, 1);
        pulse_new();
        check("R7 err cleared", err, 0);
    endtask

    task automatic t_wide_block();
        int early;
        pulse_mode(3'd4);
        pulse_new();
        feed(32, early);
        check("R2 no early pulse 32w", early, 0);
        check("R2 32w start", eng_start, 1);
        pulse_done();
    endtask

    task automatic t_partial();
        int early;
        pulse_mode(3'd0);
        feed(5, early);
        pulse_new();
        feed(16, early);
        check("R9 partial discarded", early, 0);
        check("R9 start after restart", eng_start, 1);
        pulse_done();
    endtask

    task automatic t_load();
        int cyc;
        for (int i = 0; i < 16; i++) eng_result[32*i +: 32] = 32'hA500_0000 + 32'(i * 32'h111);
        pulse_mode(3'd4);
        pulse_load();
        cyc = busy ? 1 : 0;
        @(negedge clk); mode_in = 3'd3; mode_wr = 1'b1;
        if (busy) cyc++;
        @(negedge clk); mode_wr = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        check("R6 load busy cycles", cyc, 16);
        check("R7 mode write while busy ignored", dig_len, 64);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            check("R6 copied word", rd_data, 32'hA500_0000 + 32'(i * 32'h111));
        end
        pulse_mode(3'd0);
        rd_idx = 4'd4; #1;
        check("R8 last word of short digest", rd_data, 32'hA500_0444);
        rd_idx = 4'd5; #1;
        check("R8 beyond digest reads 0", rd_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_first_and_next();
        t_reject();
        t_wide_block();
        t_partial();
        t_load();
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule